// File: doc/BRIEF.md
# Reference Divider and Periodic Rate Generator

This block turns a timekeeping reference into the pulses a real-time clock needs. It gives a one-second update tick, a one-cycle periodic event at a programmable rate, a copy of that event gated for interrupt use, and a 50 % square wave at the same rate. Everything runs in the system clock domain. The reference arrives as a strobe, `ref_half_tick`, which is high for one system cycle at each rising and each falling edge of the reference. A 32.768 kHz reference therefore gives 65536 strobes per second.

A prescaler converts the strobes into steps of a 16-bit chain that advances at 65536 Hz. The prescaler ratio comes from the selected reference frequency. A 3-bit divider code selects the reference, holds the chain in reset, or freezes it. A 4-bit rate code taps one bit of the chain, or turns the periodic output off. The calendar logic and the flag register sit downstream and consume `sec_tick`, `per_evt` and `per_irq`.

Top module: `rtc_rate_gen`

## Requirements
- R1: The divider code sets the number of strobes per chain step. Code 000 (4.194304 MHz) takes 128 strobes, code 001 (1.048576 MHz) takes 32 strobes and code 010 (32.768 kHz) takes 1 strobe. The chain therefore advances at 65536 Hz.
- R2: A rate code n from 1 to 15 makes `per_evt` a one-cycle pulse every 2^n chain steps, which is 65536/2^n Hz. Code 1 gives 32768 Hz and code 15 gives 2 Hz.
- R3: With `sqw_en` high and the rate code nonzero, `sqw_out` is a square wave at the periodic rate. It is high for exactly half of each period and rises in the same cycle as `per_evt`.
- R4: `sqw_out` is low in the cycle after `sqw_en` is low or the rate code is 0.
- R5: Rate code 0 produces no `per_evt` pulses.
- R6: `per_evt` pulses regardless of `per_en`. `per_irq` equals `per_evt` when `per_en` is held high, and stays low when `per_en` is low.
- R7: Divider codes 110 and 111 hold the chain in reset. While either code is applied there is no `sec_tick` and no `per_evt`, and `sqw_out` is low.
- R8: After the divider code leaves 110/111 for a running code, the first `sec_tick` comes after 2^15 chain steps, which is half a second. Later ticks come every 2^16 steps, which is one second. Each tick lasts one cycle.
- R9: Divider codes 011, 100 and 101 freeze the chain. No steps are taken, no pulses are produced, and `sqw_out` keeps its level.
- R10: While the synchronous reset `rst` is high, all outputs are 0. The chain restarts from the half-second point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_half_tick | input | 1 | One-cycle strobe at each reference edge |
| div_sel | input | 3 | Reference select / hold / freeze code |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| sqw_en | input | 1 | Square-wave output enable |
| per_en | input | 1 | Periodic interrupt enable |
| sec_tick | output | 1 | One-cycle pulse per second |
| per_evt | output | 1 | One-cycle periodic event |
| per_irq | output | 1 | Periodic event gated by `per_en` |
| sqw_out | output | 1 | 50 % square wave at the periodic rate |

## Verification
The bench measures the pulse spacing and the square-wave high time for each reference code. Some cases use sparse strobes, which catches a prescaler that counts system cycles instead of strobes, or that taps a bit one position off. It times the first and second one-second ticks to the exact cycle after the chain leaves reset. A design that did not reload the half-second point would tick a full second late, or too early. Further cases check that rate code 0, a low `sqw_en`, a low `per_en`, the hold codes and the freeze codes each silence exactly the output they should. A freeze code that reset the chain would drop the square-wave level. A missing gate would leak pulses.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

  typedef logic [2:0] div_code_t;

  // Reference selection codes (the code values are the programming interface)
  localparam div_code_t DIV_REF_HI  = 3'b000;  // 4.194304 MHz
  localparam div_code_t DIV_REF_MID = 3'b001;  // 1.048576 MHz
  localparam div_code_t DIV_REF_LO  = 3'b010;  // 32.768 kHz
  localparam div_code_t DIV_HOLD_A  = 3'b110;
  localparam div_code_t DIV_HOLD_B  = 3'b111;

  typedef enum logic [1:0] {
    PS_RUN,
    PS_HOLD,
    PS_FREEZE
  } ps_mode_e;

endpackage

// File: rtl/rtc_rate_prescaler.sv
module rtc_rate_prescaler
  import rtc_rate_pkg::*;
#(
  parameter int HI_DIV  = 128,
  parameter int MID_DIV = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      half_tick,
  input  div_code_t div_sel,
  output logic      step,
  output logic      hold
);

  localparam int PRE_W = $clog2(HI_DIV);
  localparam logic [PRE_W-1:0] HI_TOP  = PRE_W'(HI_DIV - 1);
  localparam logic [PRE_W-1:0] MID_TOP = PRE_W'(MID_DIV - 1);

  ps_mode_e         mode;
  logic [PRE_W-1:0] top;
  logic [PRE_W-1:0] pre_q;

  always_comb begin
    mode = PS_FREEZE;
    top  = '0;
    case (div_sel)
      DIV_REF_HI:  begin mode = PS_RUN; top = HI_TOP;  end
      DIV_REF_MID: begin mode = PS_RUN; top = MID_TOP; end
      DIV_REF_LO:  begin mode = PS_RUN; top = '0;      end
      DIV_HOLD_A, DIV_HOLD_B: mode = PS_HOLD;
      default: mode = PS_FREEZE;
    endcase
  end

  assign hold = (mode == PS_HOLD);
  // >= so that a switch to a smaller ratio never waits for a counter wrap
  assign step = (mode == PS_RUN) && half_tick && (pre_q >= top);

  always_ff @(posedge clk) begin
    if (rst || hold || step) begin
      pre_q <= '0;
    end else if (mode == PS_RUN && half_tick) begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_rate_chain.sv
module rtc_rate_chain #(
  parameter int CHAIN_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               hold,
  output logic [CHAIN_W-1:0] chain_q,
  output logic [CHAIN_W-1:0] chain_n,
  output logic               wrap
);

  localparam logic [CHAIN_W-1:0] HALF = CHAIN_W'(1) << (CHAIN_W - 1);

  always_comb begin
    if (hold)      chain_n = HALF;
    else if (step) chain_n = chain_q + 1'b1;
    else           chain_n = chain_q;
  end

  assign wrap = &chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= HALF;
    else     chain_q <= chain_n;
  end

  AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!step && !hold) |=> $stable(chain_q)) else $error("chain moved without step"); // R9

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap #(
  parameter int CHAIN_W = 16,
  parameter int RATE_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               wrap,
  input  logic [CHAIN_W-1:0] chain_q,
  input  logic [CHAIN_W-1:0] chain_n,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic               sqw_en,
  input  logic               per_en,
  output logic               sec_tick,
  output logic               per_evt,
  output logic               per_irq,
  output logic               sqw_out
);

  localparam int IDX_W = $clog2(CHAIN_W);

  logic             rate_on;
  logic [IDX_W-1:0] sel;
  logic             rise;

  assign rate_on = (rate_sel != '0);
  assign sel     = IDX_W'(rate_sel - RATE_W'(1));
  assign rise    = step && rate_on && !chain_q[sel] && chain_n[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_tick <= 1'b0;
      per_evt  <= 1'b0;
      per_irq  <= 1'b0;
      sqw_out  <= 1'b0;
    end else begin
      sec_tick <= step && wrap;
      per_evt  <= rise;
      per_irq  <= rise && per_en;
      sqw_out  <= sqw_en && rate_on && chain_n[sel];
    end
  end

  AST_SQW_OFF: assert property (@(posedge clk) disable iff (rst)
    (!sqw_en || rate_sel == '0) |=> !sqw_out) else $error("sqw active while off"); // R4
  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    per_irq |-> per_evt) else $error("irq without event"); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    per_irq |-> $past(per_en)) else $error("irq while disabled"); // R6
  AST_EVT_WITH_SQW: assert property (@(posedge clk) disable iff (rst)
    (per_evt && $past(sqw_en)) |-> sqw_out) else $error("event not on sqw rise"); // R3

endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_rate_pkg::*;
#(
  parameter int HI_DIV  = 128,
  parameter int MID_DIV = 32,
  parameter int CHAIN_W = 16,
  parameter int RATE_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_half_tick,
  input  logic [2:0]        div_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  input  logic              per_en,
  output logic              sec_tick,
  output logic              per_evt,
  output logic              per_irq,
  output logic              sqw_out
);

  logic               step;
  logic               hold;
  logic               wrap;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_n;

  rtc_rate_prescaler #(.HI_DIV(HI_DIV), .MID_DIV(MID_DIV)) u_pre (
    .clk(clk), .rst(rst), .half_tick(ref_half_tick), .div_sel(div_sel),
    .step(step), .hold(hold)
  );

  rtc_rate_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk(clk), .rst(rst), .step(step), .hold(hold),
    .chain_q(chain_q), .chain_n(chain_n), .wrap(wrap)
  );

  rtc_rate_tap #(.CHAIN_W(CHAIN_W), .RATE_W(RATE_W)) u_tap (
    .clk(clk), .rst(rst), .step(step), .wrap(wrap),
    .chain_q(chain_q), .chain_n(chain_n), .rate_sel(rate_sel),
    .sqw_en(sqw_en), .per_en(per_en),
    .sec_tick(sec_tick), .per_evt(per_evt), .per_irq(per_irq), .sqw_out(sqw_out)
  );

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!sec_tick && !per_evt && !sqw_out)) else $error("output during hold"); // R7
  AST_SEC_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> (chain_q == '0)) else $error("second tick off wrap"); // R8

endmodule

// File: tb/rtc_rate_gen_tb_top.sv
`timescale 1ns/1ps
module rtc_rate_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_half_tick = 1'b0;
  logic [2:0] div_sel = 3'b110;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       per_en = 1'b0;
  logic       sec_tick, per_evt, per_irq, sqw_out;

  int  n_run = 0;
  int  n_fail = 0;
  int  stride = 1;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  rtc_rate_gen dut_i (
    .clk(clk), .rst(rst), .ref_half_tick(ref_half_tick), .div_sel(div_sel),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .per_en(per_en),
    .sec_tick(sec_tick), .per_evt(per_evt), .per_irq(per_irq), .sqw_out(sqw_out)
  );

  // reference strobe generator: one strobe every 'stride' cycles
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ref_half_tick = (ph == 0);
      ph = (ph + 1 >= stride) ? 0 : ph + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // {div[2:0], rate[3:0], stride[1:0], period_in_cycles[15:0]}
  localparam int N_VEC = 9;
  localparam logic [24:0] VEC [N_VEC] = '{
    {3'b010, 4'd1, 2'd1, 16'd2},
    {3'b010, 4'd4, 2'd1, 16'd16},
    {3'b010, 4'd7, 2'd1, 16'd128},
    {3'b001, 4'd1, 2'd1, 16'd64},
    {3'b001, 4'd3, 2'd1, 16'd256},
    {3'b000, 4'd1, 2'd1, 16'd256},
    {3'b000, 4'd2, 2'd1, 16'd512},
    {3'b010, 4'd3, 2'd2, 16'd16},
    {3'b001, 4'd2, 2'd3, 16'd384}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt_a, cnt_b, cnt_c, first, second;
    // R10: outputs stay 0 during reset even with everything enabled
    div_sel = 3'b010; rate_sel = 4'd1; sqw_en = 1'b1; per_en = 1'b1;
    cnt_a = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cnt_a += int'(sec_tick) + int'(per_evt) + int'(per_irq) + int'(sqw_out);
    end
    chk(cnt_a == 0, "R10 reset outputs", cnt_a, 0);
    rst = 1'b0;
    per_en = 1'b0;

    // R1 R2 R3: period and duty for each vector
    for (int v = 0; v < N_VEC; v++) begin
      int period, high, pulses;
      bit found;
      period = int'(VEC[v][15:0]);
      stride = int'(VEC[v][17:16]);
      div_sel = 3'b110;
      rate_sel = VEC[v][21:18];
      repeat (4) @(negedge clk);
      div_sel = VEC[v][24:22];
      found = 1'b0;
      for (int w = 0; w < 4 * period + 1000 && !found; w++) begin
        @(negedge clk);
        if (per_evt) found = 1'b1;
      end
      chk(found, "R2 first event seen", int'(found), 1);
      pulses = 1;
      high = int'(sqw_out);
      for (int k = 1; k < period; k++) begin
        @(negedge clk);
        pulses += int'(per_evt);
        high += int'(sqw_out);
      end
      chk(pulses == 1, "R2 one event per period", pulses, 1);
      chk(high == period / 2, "R3 square wave half high", high, period / 2);
      @(negedge clk);
      chk(per_evt == 1'b1, "R1 event spacing", int'(per_evt), 1);
    end
    stride = 1;

    // R5: rate code 0 gives no events, and R4 keeps the square wave low
    div_sel = 3'b010; rate_sel = 4'd0; sqw_en = 1'b1;
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cnt_a += int'(per_evt);
      cnt_b += int'(sqw_out);
    end
    chk(cnt_a == 0, "R5 no events at rate 0", cnt_a, 0);
    chk(cnt_b == 0, "R4 sqw low at rate 0", cnt_b, 0);

    // R4: sqw disabled while events still run
    rate_sel = 4'd2; sqw_en = 1'b0;
    @(negedge clk);
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cnt_a += int'(per_evt);
      cnt_b += int'(sqw_out);
    end
    chk(cnt_b == 0, "R4 sqw low when disabled", cnt_b, 0);
    chk(cnt_a == 10, "R4 events continue", cnt_a, 10);

    // R6: interrupt gating
    rate_sel = 4'd1; per_en = 1'b1;
    @(negedge clk);
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt_a += int'(per_evt);
      cnt_b += int'(per_irq != per_evt);
    end
    chk(cnt_b == 0, "R6 irq follows event", cnt_b, 0);
    chk(cnt_a == 10, "R6 event count enabled", cnt_a, 10);
    per_en = 1'b0;
    @(negedge clk);
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt_a += int'(per_evt);
      cnt_b += int'(per_irq);
    end
    chk(cnt_b == 0, "R6 irq silent when disabled", cnt_b, 0);
    chk(cnt_a == 10, "R6 event independent of enable", cnt_a, 10);

    // R7: both hold codes silence everything
    sqw_en = 1'b1;
    for (int h = 6; h < 8; h++) begin
      div_sel = 3'(h);
      @(negedge clk);
      cnt_a = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        cnt_a += int'(sec_tick) + int'(per_evt) + int'(sqw_out);
      end
      chk(cnt_a == 0, "R7 hold code silent", cnt_a, 0);
    end

    // R9: freeze keeps the square-wave level, no events
    div_sel = 3'b010; rate_sel = 4'd2;
    for (int w = 0; w < 20 && !sqw_out; w++) @(negedge clk);
    div_sel = 3'b011;
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cnt_a += int'(per_evt);
      cnt_b += int'(sqw_out);
    end
    chk(cnt_a == 0, "R9 no events while frozen", cnt_a, 0);
    chk(cnt_b == 40, "R9 sqw level held", cnt_b, 40);

    // R8: first tick half a second after hold release, then one second
    div_sel = 3'b110; rate_sel = 4'd0; sqw_en = 1'b0;
    repeat (4) @(negedge clk);
    div_sel = 3'b010;
    first = -1; second = -1; cnt_c = 0;
    for (int i = 1; i <= 100000; i++) begin
      @(negedge clk);
      if (sec_tick) begin
        cnt_c++;
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    chk(first == 32768, "R8 first tick after half second", first, 32768);
    chk(second == 98304, "R8 second tick after one second", second, 98304);
    chk(cnt_c == 2, "R8 single-cycle ticks", cnt_c, 2);

    // R10: reset mid-run restarts at the half-second point
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!sec_tick && !per_evt && !sqw_out, "R10 reset clears outputs", int'(sec_tick), 0);
    rst = 1'b0;
    first = -1;
    for (int i = 1; i <= 33000 && first < 0; i++) begin
      @(negedge clk);
      if (sec_tick) first = i;
    end
    chk(first == 32768, "R10 restart at half second", first, 32768);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule